// File: doc/BRIEF.md
# Asynchronous Memory Access Sequencer

This block turns a single internal request into the strobe pattern for one access to an asynchronous external static memory. The access has three phases: address setup, address hold and data. Each phase length is programmable, and reads and writes take their lengths from two separate timing sets. When an access ends, a programmable turnaround gap keeps chip select high before another access can start. The requester sees a ready flag, a one-cycle done pulse, an error flag and the read data.

The controller is a five-state machine. The states are IDLE, SETUP, HOLD, DATA and TURN. The transitions are:

- IDLE to SETUP on a request that is accepted.
- SETUP to HOLD when setup ends and the hold length is non-zero.
- SETUP to DATA when setup ends and the hold length is zero.
- HOLD to DATA when hold ends.
- DATA to TURN when data ends and the gap is non-zero.
- DATA to IDLE when data ends and the gap is zero.
- TURN to IDLE when the gap ends.

A write that arrives while write strobes are disabled stays in IDLE and is answered with an error. A single down-counter times every phase. A decoder makes all strobes from the state.

Top module: `amem_seq`

## Requirements
- R1: After reset, and whenever no access is in progress, the following hold:
  - mem_cs_n, mem_adv_n, mem_oe_n and mem_we_n are all 1.
  - mem_dq_oe is 0.
  - mem_be_n is all ones.
  - req_ready is 1 in the IDLE state.
- R2: Chip select is low for a fixed number of cycles. For a read this is S+H+D and for a write it is S+H+D+1. S is the setup length, H is the hold length and D is the data length.
- R3: A programmed setup length of 0 acts as 1, and a programmed data length of 0 acts as 1. The hold length may be 0, which skips the hold phase.
- R4: A read uses only rd_setup/rd_hold/rd_data and a write uses only wr_setup/wr_hold/wr_data. The other set has no effect on the access.
- R5: After chip select rises, req_ready stays low and chip select stays high for turn_gap cycles, counted from the cycle in which chip select rises. Only then can the next request be accepted.
- R6: mem_adv_n is low for exactly the S setup cycles, with chip select low. mem_oe_n is never low while mem_adv_n is low.
- R7: On a read, mem_oe_n is low for H+D cycles. The value on mem_dq_i in the last data cycle appears on rdata while done is high.
- R8: On a write, mem_dq_oe is high for H+D+1 cycles and mem_dq_o carries the request's write data. mem_we_n is low for D cycles and is high again in the last cycle before chip select rises.
- R9: A write requested while wr_strobe_en is 0 drives no strobe. In the next cycle done and err are both 1.
- R10: done is a one-cycle pulse in the first cycle after chip select rises, and err is 0 there.
- R11: Address, byte enables, write data, timing and gap are captured when the request is accepted. Changes to the request inputs after acceptance do not affect the access in progress.
- R12: During an access mem_be_n is the bitwise inverse of the captured req_be, with bit i covering data byte i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, active high |
| req_ready | output | 1 | Block idle, request will be accepted |
| rd_setup | input | 4 | Read address setup length |
| rd_hold | input | 4 | Read address hold length |
| rd_data | input | 8 | Read data phase length |
| wr_setup | input | 4 | Write address setup length |
| wr_hold | input | 4 | Write address hold length |
| wr_data | input | 8 | Write data phase length |
| turn_gap | input | 4 | Cycles chip select stays high after an access |
| wr_strobe_en | input | 1 | Enables write strobes |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion was a rejected write |
| rdata | output | DATA_W | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Byte lane enables, active low |
| mem_addr | output | ADDR_W | Address bus |
| mem_dq_o | output | DATA_W | Data bus driven value |
| mem_dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| mem_dq_i | input | DATA_W | Data bus sampled value |

## Verification
Reads and writes are swept over every combination of:

- setup lengths 0 to 3,
- hold lengths 0 to 2,
- data lengths 0 to 3,
- gaps 0 to 2.

The idle timing set is loaded with large values each time, so using the wrong set, or mishandling a zero setup, data or hold length, changes a strobe count. Gap lengths 0 versus non-zero separate the DATA-to-IDLE path from the path through TURN. Data length 1 on writes shows whether the recovery cycle before chip select rises is present. Request inputs are changed right after acceptance, and a write with strobes disabled checks the error path.

// File: rtl/amem_pkg.sv
package amem_pkg;

    localparam int SET_W = 4;
    localparam int DAT_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HOLD,
        ST_DATA,
        ST_TURN
    } amem_state_t;

    typedef struct packed {
        logic [SET_W-1:0] setup;
        logic [SET_W-1:0] hold;
        logic [DAT_W-1:0] data;
    } amem_tim_t;

endpackage

// File: rtl/amem_timing_sel.sv
module amem_timing_sel
    import amem_pkg::*;
(
    input  logic             is_write,
    input  logic [SET_W-1:0] rd_setup,
    input  logic [SET_W-1:0] rd_hold,
    input  logic [DAT_W-1:0] rd_data,
    input  logic [SET_W-1:0] wr_setup,
    input  logic [SET_W-1:0] wr_hold,
    input  logic [DAT_W-1:0] wr_data,
    output amem_tim_t        sel
);

    amem_tim_t raw;

    always_comb begin
        if (is_write) begin
            raw.setup = wr_setup;
            raw.hold  = wr_hold;
            raw.data  = wr_data;
        end else begin
            raw.setup = rd_setup;
            raw.hold  = rd_hold;
            raw.data  = rd_data;
        end
    end

    // Zero setup and zero data lengths are raised to one cycle (R3)
    always_comb begin
        sel.hold  = raw.hold;
        sel.setup = (raw.setup == '0) ? SET_W'(1) : raw.setup;
        sel.data  = (raw.data  == '0) ? DAT_W'(1) : raw.data;
    end

endmodule

// File: rtl/amem_phase_cnt.sv
module amem_phase_cnt #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);

    // R2: each phase shortens by exactly one per cycle
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1))
        else $error("p_cnt_step_r2");

endmodule

// File: rtl/amem_strobe_dec.sv
module amem_strobe_dec
    import amem_pkg::*;
#(
    parameter int BE_W = 2
) (
    input  amem_state_t      state,
    input  logic             is_write,
    input  logic             last,
    input  logic [BE_W-1:0]  be,
    output logic             cs_n,
    output logic             adv_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             dq_oe,
    output logic [BE_W-1:0]  be_n
);

    always_comb begin
        cs_n  = 1'b1;
        adv_n = 1'b1;
        oe_n  = 1'b1;
        we_n  = 1'b1;
        dq_oe = 1'b0;
        be_n  = '1;
        unique case (state)
            ST_IDLE, ST_TURN: begin
            end
            ST_SETUP: begin
                cs_n  = 1'b0;
                adv_n = 1'b0;
                be_n  = ~be;
            end
            ST_HOLD: begin
                cs_n  = 1'b0;
                be_n  = ~be;
                oe_n  = is_write;
                dq_oe = is_write;
            end
            ST_DATA: begin
                cs_n  = 1'b0;
                be_n  = ~be;
                oe_n  = is_write;
                dq_oe = is_write;
                // last write data cycle is the recovery cycle
                we_n  = !(is_write && !last);
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/amem_seq.sv
module amem_seq
    import amem_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int TURN_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_we,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [DATA_W/8-1:0]  req_be,
    output logic                 req_ready,
    input  logic [SET_W-1:0]     rd_setup,
    input  logic [SET_W-1:0]     rd_hold,
    input  logic [DAT_W-1:0]     rd_data,
    input  logic [SET_W-1:0]     wr_setup,
    input  logic [SET_W-1:0]     wr_hold,
    input  logic [DAT_W-1:0]     wr_data,
    input  logic [TURN_W-1:0]    turn_gap,
    input  logic                 wr_strobe_en,
    output logic                 done,
    output logic                 err,
    output logic [DATA_W-1:0]    rdata,
    output logic                 mem_cs_n,
    output logic                 mem_adv_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [DATA_W/8-1:0]  mem_be_n,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_dq_o,
    output logic                 mem_dq_oe,
    input  logic [DATA_W-1:0]    mem_dq_i
);

    localparam int BE_W  = DATA_W / 8;
    localparam int CNT_W = ((DAT_W + 1) > TURN_W) ? (DAT_W + 1) : TURN_W;
    localparam int GAP_W = TURN_W + 1;

    amem_state_t         state_q, state_d;
    amem_tim_t           tim_sel, tim_q;
    logic [TURN_W-1:0]   turn_q;
    logic                acc_we_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [BE_W-1:0]     be_q;
    logic                cnt_load;
    logic [CNT_W-1:0]    cnt_val;
    logic                cnt_last;
    logic                accept;
    logic                err_req;
    logic                data_end;
    logic [CNT_W-1:0]    data_m1;
    logic                done_q, err_q;
    logic [DATA_W-1:0]   rdata_q;

    amem_timing_sel u_sel (
        .is_write (req_we),
        .rd_setup (rd_setup),
        .rd_hold  (rd_hold),
        .rd_data  (rd_data),
        .wr_setup (wr_setup),
        .wr_hold  (wr_hold),
        .wr_data  (wr_data),
        .sel      (tim_sel)
    );

    amem_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .last     (cnt_last)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign err_req   = accept && req_we && !wr_strobe_en;
    assign data_end  = (state_q == ST_DATA) && cnt_last;
    // writes carry one extra recovery cycle in the data phase
    assign data_m1   = acc_we_q ? CNT_W'(tim_q.data) : CNT_W'(tim_q.data) - 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and phase counter loading
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && !err_req) begin
                    state_d  = ST_SETUP;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(tim_sel.setup) - 1'b1;
                end
            end
            ST_SETUP: begin
                if (cnt_last) begin
                    cnt_load = 1'b1;
                    if (tim_q.hold != '0) begin
                        state_d = ST_HOLD;
                        cnt_val = CNT_W'(tim_q.hold) - 1'b1;
                    end else begin
                        state_d = ST_DATA;
                        cnt_val = data_m1;
                    end
                end
            end
            ST_HOLD: begin
                if (cnt_last) begin
                    state_d  = ST_DATA;
                    cnt_load = 1'b1;
                    cnt_val  = data_m1;
                end
            end
            ST_DATA: begin
                if (cnt_last) begin
                    if (turn_q != '0) begin
                        state_d  = ST_TURN;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(turn_q) - 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_TURN: begin
                if (cnt_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // request capture (R11)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_we_q <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            be_q     <= '0;
            tim_q    <= '0;
            turn_q   <= '0;
        end else if (accept) begin
            acc_we_q <= req_we;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            be_q     <= req_be;
            tim_q    <= tim_sel;
            turn_q   <= turn_gap;
        end
    end

    // completion and read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= data_end || err_req;
            err_q  <= err_req;
            if (data_end && !acc_we_q) begin
                rdata_q <= mem_dq_i;
            end
        end
    end

    amem_strobe_dec #(.BE_W(BE_W)) u_dec (
        .state    (state_q),
        .is_write (acc_we_q),
        .last     (cnt_last),
        .be       (be_q),
        .cs_n     (mem_cs_n),
        .adv_n    (mem_adv_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .dq_oe    (mem_dq_oe),
        .be_n     (mem_be_n)
    );

    assign done     = done_q;
    assign err      = err_q;
    assign rdata    = rdata_q;
    assign mem_addr = addr_q;
    assign mem_dq_o = wdata_q;

    // ---- turnaround checker state ----
    logic [GAP_W-1:0]  gap_cnt;
    logic [TURN_W-1:0] gap_need;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt  <= '1;
            gap_need <= '0;
        end else begin
            if (!mem_cs_n) begin
                gap_cnt <= '0;
            end else if (gap_cnt != '1) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
            if (data_end) begin
                gap_need <= turn_q;
            end
        end
    end

    p_turn_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> (int'(gap_cnt) >= int'(gap_need)))
        else $error("p_turn_gap_r5");

    p_idle_strobes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n && !mem_dq_oe))
        else $error("p_idle_strobes_r1");

    p_adv_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> (!mem_cs_n && mem_oe_n && mem_we_n))
        else $error("p_adv_in_cs_r6");

    p_we_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |-> $past(mem_we_n))
        else $error("p_we_release_r8");

    p_we_with_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && mem_oe_n))
        else $error("p_we_with_data_r8");

    p_done_at_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |-> (done && !err))
        else $error("p_done_at_rise_r10");

    p_err_no_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && mem_cs_n))
        else $error("p_err_no_cs_r9");

    p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$rose(!mem_cs_n)) |-> $stable(mem_addr))
        else $error("p_addr_stable_r11");

    p_be_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (&mem_be_n))
        else $error("p_be_idle_r12");

endmodule

// File: tb/amem_seq_tb_top.sv
module amem_seq_tb_top;

    localparam int AW = 24;
    localparam int DW = 16;
    localparam int BW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [BW-1:0] req_be = '0;
    logic          req_ready;
    logic [3:0]    rd_setup = '0, rd_hold = '0, wr_setup = '0, wr_hold = '0;
    logic [7:0]    rd_data = '0, wr_data = '0;
    logic [3:0]    turn_gap = '0;
    logic          wr_strobe_en = 1'b1;
    logic          done, err;
    logic [DW-1:0] rdata;
    logic          mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [BW-1:0] mem_be_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_o, mem_dq_i;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    function automatic logic [DW-1:0] model(input logic [AW-1:0] a);
        return a[DW-1:0] ^ 16'h5A3C;
    endfunction

    assign mem_dq_i = mem_oe_n ? '0 : model(mem_addr);

    amem_seq #(.ADDR_W(AW), .DATA_W(DW), .TURN_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rd_setup(rd_setup), .rd_hold(rd_hold),
        .rd_data(rd_data), .wr_setup(wr_setup), .wr_hold(wr_hold),
        .wr_data(wr_data), .turn_gap(turn_gap), .wr_strobe_en(wr_strobe_en),
        .done(done), .err(err), .rdata(rdata), .mem_cs_n(mem_cs_n),
        .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_access(input bit we, input int s, input int h, input int d,
                              input int t, input int idx);
        logic [AW-1:0] a;
        logic [BW-1:0] b;
        logic [DW-1:0] w;
        int se, de, cs, adv, oe, wl, dqo, badaddr, badbe, badwd, cyc, g;
        bit last_we;
        a  = AW'(24'h010000 + idx * 37);
        b  = BW'((idx % 3) + 1);
        w  = DW'(16'hB000 + idx);
        se = (s == 0) ? 1 : s;
        de = (d == 0) ? 1 : d;
        @(negedge clk);
        // R4: the unused timing set holds large values
        if (we) begin
            wr_setup = 4'(s); wr_hold = 4'(h); wr_data = 8'(d);
            rd_setup = 4'd15; rd_hold = 4'd15; rd_data = 8'd200;
        end else begin
            rd_setup = 4'(s); rd_hold = 4'(h); rd_data = 8'(d);
            wr_setup = 4'd15; wr_hold = 4'd15; wr_data = 8'd200;
        end
        turn_gap = 4'(t);
        wr_strobe_en = 1'b1;
        req_we = we; req_addr = a; req_be = b; req_wdata = w; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        // R11: disturb the request inputs after acceptance
        req_valid = 1'b0; req_addr = ~a; req_be = ~b; req_wdata = ~w;
        rd_setup = 4'd0; rd_hold = 4'd9; rd_data = 8'd0;
        wr_setup = 4'd0; wr_hold = 4'd9; wr_data = 8'd0; turn_gap = 4'd9;
        cs = 0; adv = 0; oe = 0; wl = 0; dqo = 0; badaddr = 0; badbe = 0; badwd = 0;
        cyc = 0; last_we = 1'b0;
        while (!done && cyc < 300) begin
            if (!mem_cs_n) begin
                cs++;
                if (!mem_adv_n) begin
                    adv++;
                    if (cs > se) badaddr += 100;
                end
                if (!mem_oe_n) oe++;
                if (!mem_we_n) wl++;
                if (mem_dq_oe) begin
                    dqo++;
                    if (mem_dq_o != w) badwd++;
                end
                if (mem_addr != a) badaddr++;
                if (mem_be_n != ~b) badbe++;
                last_we = mem_we_n;
            end
            cyc++;
            @(negedge clk);
        end
        chk(cs == (we ? se + h + de + 1 : se + h + de), "R2 cs low cycles", cs,
            we ? se + h + de + 1 : se + h + de);
        chk(adv == se, "R3/R6 adv low cycles", adv, se);
        chk(badaddr == 0, "R11 address held", badaddr, 0);
        chk(badbe == 0, "R12 byte enables", badbe, 0);
        chk(mem_cs_n && done && !err, "R10 done with cs high, no err",
            {mem_cs_n, done, err}, 3'b110);
        if (we) begin
            chk(oe == 0, "R4 no oe on write", oe, 0);
            chk(wl == de, "R8 we low cycles", wl, de);
            chk(dqo == h + de + 1, "R8 data drive cycles", dqo, h + de + 1);
            chk(badwd == 0, "R8 write data value", badwd, 0);
            chk(last_we == 1'b1, "R8 we high before cs rise", last_we, 1);
        end else begin
            chk(oe == h + de, "R7 oe low cycles", oe, h + de);
            chk(wl == 0 && dqo == 0, "R4 no write strobes on read", wl + dqo, 0);
            chk(rdata == model(a), "R7 read data", rdata, model(a));
        end
        g = 0;
        while (!req_ready && g < 40) begin
            if (!mem_cs_n) g += 100;
            g++;
            @(negedge clk);
            if (g == 1) chk(!done, "R10 done one cycle", done, 0);
        end
        chk(g == t, "R5 turnaround cycles", g, t);
        if (t == 0) begin
            @(negedge clk);
            chk(!done, "R10 done one cycle", done, 0);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int idx;
        idx = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_cs_n && mem_adv_n && mem_oe_n && mem_we_n, "R1 strobes high in reset",
            {mem_cs_n, mem_adv_n, mem_oe_n, mem_we_n}, 4'hF);
        chk(!mem_dq_oe && mem_be_n == '1, "R1 bus released in reset",
            {mem_dq_oe, mem_be_n}, 3'b011);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !done, "R1 ready after reset", {req_ready, done}, 2'b10);

        for (int we = 0; we < 2; we++)
            for (int s = 0; s < 4; s++)
                for (int h = 0; h < 3; h++)
                    for (int d = 0; d < 4; d++)
                        for (int t = 0; t < 3; t++) begin
                            run_access(we[0], s, h, d, t, idx);
                            idx++;
                        end

        // R9: write with strobes disabled
        @(negedge clk);
        wr_strobe_en = 1'b0;
        req_we = 1'b1; req_addr = 24'h00ABCD; req_be = 2'b11; req_valid = 1'b1;
        wr_setup = 4'd3; wr_hold = 4'd2; wr_data = 8'd3; turn_gap = 4'd2;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(done && err, "R9 immediate done with err", {done, err}, 2'b11);
        chk(mem_cs_n && mem_we_n && !mem_dq_oe, "R9 no strobes",
            {mem_cs_n, mem_we_n, mem_dq_oe}, 3'b110);
        @(negedge clk);
        chk(!done && !err && mem_cs_n && req_ready, "R9 single pulse, idle",
            {done, err, mem_cs_n, req_ready}, 4'b0011);
        wr_strobe_en = 1'b1;
        // R1: idle again after all traffic
        chk(mem_cs_n && mem_oe_n && mem_we_n && mem_be_n == '1, "R1 idle after traffic",
            {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule